// File: doc/BRIEF.md
# Iterative XTEA Block Cipher Engine

This engine encrypts or deciphers a single 64-bit block, carried as two 32-bit halves, under a 128-bit key held inside the block. A host first loads the four key words through a small word-addressed register port. It then presents the two halves, a direction bit and a round count, and pulses start. From that point the engine sequences every round on its own and needs no further host action.

Each clock performs one half-round, so a count of N full cycles takes 2N clocks. When the last half-round retires, busy drops and done rises. The result halves are then held at the outputs until the next accepted start. While the engine is busy, start pulses and key writes are discarded. This keeps a running operation and its key consistent.

Top module: `xtea_engine`

## Requirements
- R1: After the active-low asynchronous reset, busy and done are 0, both result halves read 0, and all four key words read back as 0.
- R2: When busy is 0, a key write with address 0 to 3 stores the data word. The key read port returns the word selected by the read address combinationally, and key index i addresses word i.
- R3: With the direction bit at 0 (encrypt), the sum starts at 0. Each cycle first adds (mix(v1) XOR (sum + key[sum & 3])) to v0, then adds 0x9E3779B9 to sum, then adds (mix(v0) XOR (sum + key[(sum >> 11) & 3])) to v1. Here mix(x) = ((x << 4) XOR (x >> 5)) + x, with logical shifts and arithmetic modulo 2^32.
- R4: With the direction bit at 1 (decrypt), the sum starts at 0x9E3779B9 times N, truncated to 32 bits. Each cycle first subtracts (mix(v0) XOR (sum + key[(sum >> 11) & 3])) from v1, then subtracts 0x9E3779B9 from sum, then subtracts (mix(v1) XOR (sum + key[sum & 3])) from v0. Decrypting an encrypted block with the same key and count returns the plaintext.
- R5: If start is sampled on clock edge E0 with a nonzero count N, busy is 1 after E0 and stays 1 until edge E0+2N. After that edge, busy is 0 and done is 1. Busy and done are never both 1.
- R6: Done and both result halves keep their values for as long as no new start is accepted.
- R7: A start pulse sampled while busy is 1 is ignored. The running operation completes with its original result and timing.
- R8: A key write sampled while busy is 1 is ignored, including a write on the edge of the final half-round. The key word keeps its old value.
- R9: The count is programmable (default use 20). Counts of 1 and 32 produce the results of R3 and R4 for that count.
- R10: A start with a count of 0 leaves busy at 0, sets done after E0, and returns the input halves unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| keyWe | input | 1 | Key word write strobe |
| keyAddr | input | 2 | Key word index for write and read |
| keyWdata | input | 32 | Key word write data |
| keyRdata | output | 32 | Key word read data |
| start | input | 1 | Launch pulse, honoured only when idle |
| decrypt | input | 1 | Direction: 0 encrypt, 1 decrypt |
| cycles | input | CNT_W | Number of full cycles N |
| v0In | input | 32 | First input half |
| v1In | input | 32 | Second input half |
| busy | output | 1 | Operation in progress |
| done | output | 1 | Result valid, held until next start |
| v0Out | output | 32 | First result half |
| v1Out | output | 32 | Second result half |

## Verification
A key write or a start can land on the very edge where the final half-round retires. At that edge busy is still sampled high, so the write must be dropped even though done rises in the same edge. The bench provokes this by counting clocks from launch and driving a key write into the last busy cycle. It judges the outcome two ways: the scoreboard result must match the model computed with the old key, and a later read of that word must return the old value. A start injected in mid-run is judged the same way, by an unchanged result and an unchanged clock count to done.

// File: rtl/xtea_pkg.sv
package xtea_pkg;
  localparam int WORD_W   = 32;
  localparam int KEY_WRDS = 4;
  localparam int KADDR_W  = $clog2(KEY_WRDS);
  localparam logic [WORD_W-1:0] ROUND_DELTA = 32'h9E3779B9;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic load;    // capture inputs and initial sum
    logic step;    // perform one half-round
    logic second;  // 0: first half of a cycle, 1: second half
    logic dec;     // direction for this strobe
  } xteaCtrl_t;
endpackage

// File: rtl/xtea_keystore.sv
module xtea_keystore
  import xtea_pkg::*;
(
  input  logic                             clk,
  input  logic                             rstN,
  input  logic                             busy,
  input  logic                             we,
  input  logic [KADDR_W-1:0]               addr,
  input  logic [WORD_W-1:0]                wdata,
  output logic [WORD_W-1:0]                rdata,
  output logic [KEY_WRDS-1:0][WORD_W-1:0]  keyWords
);
  logic [KEY_WRDS-1:0][WORD_W-1:0] keyQ;

  for (genvar i = 0; i < KEY_WRDS; i++) begin : gWord
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) keyQ[i] <= '0;
      else if (we && !busy && (addr == KADDR_W'(i))) keyQ[i] <= wdata;
    end
  end

  assign rdata    = keyQ[addr];
  assign keyWords = keyQ;

  // R8: a write while busy never lands
  a_r8_key_frozen: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> $stable(keyQ));
  // R2: an idle write is visible on the next cycle
  a_r2_write_lands: assert property (@(posedge clk) disable iff (!rstN)
    (we && !busy) |=> (keyQ[$past(addr)] == $past(wdata)));
endmodule

// File: rtl/xtea_datapath.sv
module xtea_datapath
  import xtea_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  xteaCtrl_t                        ctrlIn,
  input  logic [CNT_W-1:0]                 cycles,
  input  logic [WORD_W-1:0]                v0In,
  input  logic [WORD_W-1:0]                v1In,
  input  logic [KEY_WRDS-1:0][WORD_W-1:0]  keyWords,
  output logic [WORD_W-1:0]                v0Out,
  output logic [WORD_W-1:0]                v1Out
);
  logic [WORD_W-1:0] v0Q, v1Q, sumQ;
  logic [WORD_W-1:0] target, other, mixed, keySel, term, newVal, sumNext, initSum;
  logic              updV1;
  logic [KADDR_W-1:0] keyIdx;

  // the half written and the key index source coincide:
  // encrypt second half and decrypt first half touch v1 with sum bits 12:11
  assign updV1   = (!ctrlIn.dec) == ctrlIn.second;
  assign target  = updV1 ? v1Q : v0Q;
  assign other   = updV1 ? v0Q : v1Q;
  assign keyIdx  = updV1 ? sumQ[12:11] : sumQ[1:0];
  assign keySel  = keyWords[keyIdx];
  assign mixed   = ((other << 4) ^ (other >> 5)) + other;
  assign term    = mixed ^ (sumQ + keySel);
  assign newVal  = ctrlIn.dec ? (target - term) : (target + term);
  assign initSum = ctrlIn.dec ? WORD_W'(ROUND_DELTA * WORD_W'(cycles)) : '0;

  always_comb begin
    sumNext = sumQ;
    if (!ctrlIn.second) sumNext = ctrlIn.dec ? (sumQ - ROUND_DELTA) : (sumQ + ROUND_DELTA);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      v0Q  <= '0;
      v1Q  <= '0;
      sumQ <= '0;
    end else if (ctrlIn.load) begin
      v0Q  <= v0In;
      v1Q  <= v1In;
      sumQ <= initSum;
    end else if (ctrlIn.step) begin
      sumQ <= sumNext;
      if (updV1) v1Q <= newVal;
      else       v0Q <= newVal;
    end
  end

  assign v0Out = v0Q;
  assign v1Out = v1Q;

  // R6: with no strobe, the state is frozen
  a_r6_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!ctrlIn.load && !ctrlIn.step) |=> ($stable(v0Q) && $stable(v1Q) && $stable(sumQ)));
  // R3: a half-round writes only one half
  a_r3_one_half: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlIn.step && !ctrlIn.load && updV1) |=> $stable(v0Q));
  // R4: sum is untouched in a second half-round
  a_r4_sum_second: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlIn.step && !ctrlIn.load && ctrlIn.second) |=> $stable(sumQ));
endmodule

// File: rtl/xtea_sequencer.sv
module xtea_sequencer
  import xtea_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic             decrypt,
  input  logic [CNT_W-1:0] cycles,
  output xteaCtrl_t        ctrlOut,
  output logic             busy,
  output logic             done
);
  localparam int REM_W = CNT_W + 1;

  logic             busyQ, doneQ, phaseQ, decQ;
  logic [REM_W-1:0] remQ;
  logic             accept;

  assign accept = start && !busyQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busyQ  <= 1'b0;
      doneQ  <= 1'b0;
      phaseQ <= 1'b0;
      decQ   <= 1'b0;
      remQ   <= '0;
    end else if (accept) begin
      decQ   <= decrypt;
      phaseQ <= 1'b0;
      remQ   <= {cycles, 1'b0};
      busyQ  <= (cycles != '0);
      doneQ  <= (cycles == '0);
    end else if (busyQ) begin
      phaseQ <= !phaseQ;
      remQ   <= remQ - 1'b1;
      if (remQ == REM_W'(1)) begin
        busyQ <= 1'b0;
        doneQ <= 1'b1;
      end
    end
  end

  always_comb begin
    ctrlOut.load   = accept;
    ctrlOut.step   = busyQ;
    ctrlOut.second = phaseQ;
    ctrlOut.dec    = accept ? decrypt : decQ;
  end

  assign busy = busyQ;
  assign done = doneQ;

  // R5: busy and done are exclusive
  a_r5_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(busyQ && doneQ));
  // R5: a busy run ends only in done
  a_r5_ends_done: assert property (@(posedge clk) disable iff (!rstN)
    (busyQ && !start) |=> (busyQ || doneQ));
  // R7: a start while busy does not reload the counter
  a_r7_start_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (busyQ && start) |=> (remQ == $past(remQ) - 1'b1) && (decQ == $past(decQ)));
  // R6: done falls only on an accepted start
  a_r6_done_holds: assert property (@(posedge clk) disable iff (!rstN)
    (doneQ && !start) |=> doneQ);
endmodule

// File: rtl/xtea_engine.sv
module xtea_engine
  import xtea_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                keyWe,
  input  logic [1:0]          keyAddr,
  input  logic [31:0]         keyWdata,
  output logic [31:0]         keyRdata,
  input  logic                start,
  input  logic                decrypt,
  input  logic [CNT_W-1:0]    cycles,
  input  logic [31:0]         v0In,
  input  logic [31:0]         v1In,
  output logic                busy,
  output logic                done,
  output logic [31:0]         v0Out,
  output logic [31:0]         v1Out
);
  xteaCtrl_t                       ctrl;
  logic [KEY_WRDS-1:0][WORD_W-1:0] keyWords;

  xtea_keystore uKeys (
    .clk(clk), .rstN(rstN), .busy(busy), .we(keyWe), .addr(keyAddr),
    .wdata(keyWdata), .rdata(keyRdata), .keyWords(keyWords)
  );

  xtea_sequencer #(.CNT_W(CNT_W)) uSeq (
    .clk(clk), .rstN(rstN), .start(start), .decrypt(decrypt), .cycles(cycles),
    .ctrlOut(ctrl), .busy(busy), .done(done)
  );

  xtea_datapath #(.CNT_W(CNT_W)) uPath (
    .clk(clk), .rstN(rstN), .ctrlIn(ctrl), .cycles(cycles), .v0In(v0In),
    .v1In(v1In), .keyWords(keyWords), .v0Out(v0Out), .v1Out(v1Out)
  );
endmodule

// File: tb/tb_xtea_engine.sv
module tb_xtea_engine;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W = 8;

  logic clk = 1'b0, rstN = 1'b0;
  logic keyWe = 1'b0;
  logic [1:0] keyAddr = '0;
  logic [31:0] keyWdata = '0, keyRdata;
  logic start = 1'b0, decrypt = 1'b0;
  logic [CNT_W-1:0] cycles = '0;
  logic [31:0] v0In = '0, v1In = '0, v0Out, v1Out;
  logic busy, done;

  xtea_engine #(.CNT_W(CNT_W)) dut (
    .clk(clk), .rstN(rstN), .keyWe(keyWe), .keyAddr(keyAddr), .keyWdata(keyWdata),
    .keyRdata(keyRdata), .start(start), .decrypt(decrypt), .cycles(cycles),
    .v0In(v0In), .v1In(v1In), .busy(busy), .done(done), .v0Out(v0Out), .v1Out(v1Out)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, fails = 0;
  logic [31:0] kw [4] = '{32'h0, 32'h0, 32'h0, 32'h0};

  typedef struct { logic [31:0] a; logic [31:0] b; string tag; } item_t;
  item_t sbq[$];
  logic pending = 1'b0;
  logic finished = 1'b0;

  task automatic check(input logic ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mix(input logic [31:0] x);
    return ((x << 4) ^ (x >> 5)) + x;
  endfunction

  function automatic logic [63:0] model(input logic dec, input logic [31:0] a, input logic [31:0] b, input int n);
    logic [31:0] s;
    s = dec ? 32'(32'h9E3779B9 * n) : 32'h0;
    for (int i = 0; i < n; i++) begin
      if (!dec) begin
        a = a + (mix(b) ^ (s + kw[s[1:0]]));
        s = s + 32'h9E3779B9;
        b = b + (mix(a) ^ (s + kw[s[12:11]]));
      end else begin
        b = b - (mix(a) ^ (s + kw[s[12:11]]));
        s = s - 32'h9E3779B9;
        a = a - (mix(b) ^ (s + kw[s[1:0]]));
      end
    end
    return {a, b};
  endfunction

  task automatic writeKey(input int idx, input logic [31:0] val);
    keyWe = 1'b1; keyAddr = 2'(idx); keyWdata = val;
    @(negedge clk);
    keyWe = 1'b0;
    if (!busy) kw[idx] = val;
  endtask

  // driver: launches one operation and pushes the expected result
  // poke 1: start pulse mid-run; poke 2: key write on the final busy cycle
  task automatic run(input logic dec, input int n, input logic [31:0] a, input logic [31:0] b,
                     input string tag, input int poke);
    logic [63:0] e;
    item_t it;
    int cnt;
    e = model(dec, a, b, n);
    it.a = e[63:32]; it.b = e[31:0]; it.tag = tag;
    sbq.push_back(it);
    decrypt = dec; cycles = CNT_W'(n); v0In = a; v1In = b; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    pending = 1'b1;
    if (n > 0) check(busy === 1'b1 && done === 1'b0, "R5 busy after start", {62'b0, busy, done}, 64'h2);
    else check(busy === 1'b0, "R10 no busy for zero count", {63'b0, busy}, 64'h0);
    cnt = 0;
    while (!done) begin
      if (poke == 1 && cnt == 2) begin
        start = 1'b1; decrypt = !dec; cycles = 8'd3; v0In = ~a;
      end
      if (poke == 2 && cnt == 2*n - 1) begin
        keyWe = 1'b1; keyAddr = 2'd1; keyWdata = 32'hDEAD_0001;
      end
      @(negedge clk);
      start = 1'b0; keyWe = 1'b0;
      cnt++;
    end
    check(cnt == 2*n, {tag, " R5 clocks to done"}, 64'(cnt), 64'(2*n));
    check(busy === 1'b0, {tag, " R5 busy low at done"}, {63'b0, busy}, 64'h0);
    while (pending) @(negedge clk);
  endtask

  // monitor: pops expected items as results appear
  initial begin
    item_t it;
    forever begin
      @(negedge clk);
      if (pending && done) begin
        if (sbq.size() == 0) check(1'b0, "scoreboard empty", 64'h0, 64'h0);
        else begin
          it = sbq.pop_front();
          check(v0Out === it.a && v1Out === it.b, it.tag, {v0Out, v1Out}, {it.a, it.b});
        end
        pending = 1'b0;
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      check(1'b0, "watchdog expired", 64'h0, 64'h1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [63:0] ct, r;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(busy === 1'b0 && done === 1'b0, "R1 flags", {62'b0, busy, done}, 64'h0);
    check(v0Out === 32'h0 && v1Out === 32'h0, "R1 halves", {v0Out, v1Out}, 64'h0);
    for (int i = 0; i < 4; i++) begin
      keyAddr = 2'(i); #1;
      check(keyRdata === 32'h0, "R1 key word zero", {32'h0, keyRdata}, 64'h0);
    end
    rstN = 1'b1;
    @(negedge clk);
    // R2: key write and readback
    writeKey(0, 32'h3A91_C407); writeKey(1, 32'h5E0D_22B8);
    writeKey(2, 32'hB7F4_6A13); writeKey(3, 32'h0C58_E9D6);
    for (int i = 3; i >= 0; i--) begin
      keyAddr = 2'(i); #1;
      check(keyRdata === kw[i], "R2 key readback", {32'h0, keyRdata}, {32'h0, kw[i]});
    end
    // R3 / R4 default count
    run(1'b0, 20, 32'h0123_4567, 32'h89AB_CDEF, "R3 encrypt n20", 0);
    ct = {v0Out, v1Out};
    // R6: result and done hold
    repeat (5) @(negedge clk);
    check(done === 1'b1 && {v0Out, v1Out} === ct, "R6 hold", {v0Out, v1Out}, ct);
    run(1'b1, 20, ct[63:32], ct[31:0], "R4 decrypt n20", 0);
    check({v0Out, v1Out} === 64'h0123_4567_89AB_CDEF, "R4 roundtrip", {v0Out, v1Out}, 64'h0123_4567_89AB_CDEF);
    // R9: other counts
    run(1'b0, 1, 32'hFFFF_FFFF, 32'h0000_0001, "R9 encrypt n1", 0);
    run(1'b1, 1, 32'h1357_9BDF, 32'h2468_ACE0, "R9 decrypt n1", 0);
    run(1'b0, 32, 32'hA5A5_5A5A, 32'h0F0F_F0F0, "R9 encrypt n32", 0);
    r = {v0Out, v1Out};
    run(1'b1, 32, r[63:32], r[31:0], "R9 decrypt n32", 0);
    check({v0Out, v1Out} === 64'hA5A5_5A5A_0F0F_F0F0, "R9 roundtrip n32", {v0Out, v1Out}, 64'hA5A5_5A5A_0F0F_F0F0);
    // R10: zero count
    run(1'b0, 0, 32'hCAFE_F00D, 32'h1234_5678, "R10 zero count", 0);
    // R7: start pulse while busy
    run(1'b0, 7, 32'h7777_0000, 32'h0000_8888, "R7 start ignored", 1);
    // R8: key write landing on final half-round
    run(1'b1, 5, 32'h4242_4242, 32'h9999_1111, "R8 write ignored", 2);
    keyAddr = 2'd1; #1;
    check(keyRdata === 32'h5E0D_22B8, "R8 key unchanged", {32'h0, keyRdata}, 64'h5E0D_22B8);
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule